// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

A 32-pin general-purpose I/O bank sitting behind a simple word-addressed read/write port. Each pin is owned either by the GPIO logic or by one of two internal peripheral functions (A or B). Every configuration attribute is changed through a pair of strobe registers: one sets the bits written as 1, the other clears them. No read-modify-write sequence is ever needed, so two software agents can touch different pins without racing.

Pad inputs pass through a two-flop synchronizer. An optional per-pin glitch filter follows, then a change detector. The detector latches a status bit on every rising and every falling edge. Reading the change status register returns the latched bits and clears them in that same access. One interrupt line is the OR, over all pins, of status bits qualified by a mask.

The bus port takes one access per cycle with no back-pressure. A write is committed at the clock edge that ends the cycle in which `bus_en` and `bus_wr` are high. Read data is combinational on `bus_rdata` during the cycle in which `bus_en` is high and `bus_wr` is low.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, GPIO owns every pin (ownership status all ones) and pull-ups are all on (pull-up status and `pad_pullup` all ones). Output enable, output data, filter, open-drain, mask, peripheral select and change status all read 0, and `irq_out` is 0.
- R2: In every set register, each 1 bit sets that pin's attribute and each 0 bit leaves it unchanged. In every clear register, each 1 bit clears that pin's attribute and each 0 bit leaves it unchanged. Bit n always addresses pin n. Word offsets are:
  - ownership set/clear/status at 0/1/2
  - output-enable at 3/4/5
  - filter at 6/7/8
  - data at 9/10/11
  - pin level at 12
  - mask set/clear/status at 13/14/15
  - change status at 16
  - open-drain at 17/18/19
  - pull-up clear/set/status at 20/21/22
  - peripheral A select at 23, B select at 24, select status at 25
- R3: For a pin not owned by GPIO, `pad_out`/`pad_oe` come from peripheral B when its select status bit is 1, and from peripheral A when the bit is 0. Writing A select clears the bit; writing B select sets it.
- R4: For a GPIO-owned pin, `pad_out` equals the data bit and `pad_oe` equals the output-enable bit.
- R5: With open-drain on, a pin whose driven value is 1 has `pad_oe` low. A pin whose driven value is 0 drives `pad_out` low, with `pad_oe` following the owner's enable.
- R6: The pin-level register (offset 12) shows `pad_in` for every pin, whatever the owner, two clock edges after the pad changes.
- R7: With the filter off, every rising edge and every falling edge of a pad sets that pin's change status bit.
- R8: Reading offset 16 returns the latched change bits and clears them. A change detected in the same cycle as that read stays latched for the next read.
- R9: `irq_out` is 1 exactly when some pin has both its change status bit and its mask bit set. The mask reads back at offset 15.
- R10: With the filter on, a pad pulse lasting one clock cycle sets no change bit, and a pulse lasting two cycles is seen.
- R11: `pad_pullup` equals the pull-up status register.
- R12: Set and clear registers, and unmapped offsets, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data |
| pad_in | input | 32 | Pad levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pullup | output | 32 | Pull-up control |
| pa_out | input | 32 | Peripheral A output values |
| pa_oe | input | 32 | Peripheral A output enables |
| pb_out | input | 32 | Peripheral B output values |
| pb_oe | input | 32 | Peripheral B output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
The assertions assume that `pad_in` stays low while reset is held, since the synchronizer resets to 0 and a high pad would otherwise count as a change on release. They also assume that the bus inputs are stable across each clock edge. The stimulus changes pads and bus signals only on falling edges and holds the pads at 0 through reset. A pad is set to 1 only after the change bits for it have been read out. This lets each expected status value be worked out from the pulses applied since the last read.

// File: rtl/pinbank_pkg.sv
`timescale 1ns/1ps
package pinbank_pkg;
  localparam int unsigned REG_AW = 5;

  typedef enum logic [REG_AW-1:0] {
    RA_OWN_SET = 5'd0,  RA_OWN_CLR = 5'd1,  RA_OWN_ST = 5'd2,
    RA_OE_SET  = 5'd3,  RA_OE_CLR  = 5'd4,  RA_OE_ST  = 5'd5,
    RA_FLT_SET = 5'd6,  RA_FLT_CLR = 5'd7,  RA_FLT_ST = 5'd8,
    RA_DAT_SET = 5'd9,  RA_DAT_CLR = 5'd10, RA_DAT_ST = 5'd11,
    RA_PIN_ST  = 5'd12,
    RA_MSK_SET = 5'd13, RA_MSK_CLR = 5'd14, RA_MSK_ST = 5'd15,
    RA_CHG_ST  = 5'd16,
    RA_OD_SET  = 5'd17, RA_OD_CLR  = 5'd18, RA_OD_ST  = 5'd19,
    RA_PU_CLR  = 5'd20, RA_PU_SET  = 5'd21, RA_PU_ST  = 5'd22,
    RA_SEL_A   = 5'd23, RA_SEL_B   = 5'd24, RA_SEL_ST = 5'd25
  } reg_addr_e;

  // attribute slots held in set/clear registers
  localparam int AT_OWN = 0;
  localparam int AT_OE  = 1;
  localparam int AT_FLT = 2;
  localparam int AT_DAT = 3;
  localparam int AT_MSK = 4;
  localparam int AT_OD  = 5;
  localparam int AT_PU  = 6;
  localparam int AT_SEL = 7;
  localparam int NATTR  = 8;

  function automatic logic [REG_AW-1:0] attr_set_addr(int a);
    case (a)
      AT_OWN:  return RA_OWN_SET;
      AT_OE:   return RA_OE_SET;
      AT_FLT:  return RA_FLT_SET;
      AT_DAT:  return RA_DAT_SET;
      AT_MSK:  return RA_MSK_SET;
      AT_OD:   return RA_OD_SET;
      AT_PU:   return RA_PU_SET;
      default: return RA_SEL_B;
    endcase
  endfunction

  function automatic logic [REG_AW-1:0] attr_clr_addr(int a);
    case (a)
      AT_OWN:  return RA_OWN_CLR;
      AT_OE:   return RA_OE_CLR;
      AT_FLT:  return RA_FLT_CLR;
      AT_DAT:  return RA_DAT_CLR;
      AT_MSK:  return RA_MSK_CLR;
      AT_OD:   return RA_OD_CLR;
      AT_PU:   return RA_PU_CLR;
      default: return RA_SEL_A;
    endcase
  endfunction

  function automatic bit attr_rst_ones(int a);
    return (a == AT_OWN) || (a == AT_PU);
  endfunction
endpackage

// File: rtl/pinbank_setclr_reg.sv
`timescale 1ns/1ps
module pinbank_setclr_reg #(
  parameter int W        = 32,
  parameter bit RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= RST_ONES ? '1 : '0;
    else if (set_stb) q <= q | wdata;
    else if (clr_stb) q <= q & ~wdata;
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(q));

  // R2
  zero_bits_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb) |=> (((q ^ $past(q)) & ~$past(wdata)) == '0));
endmodule

// File: rtl/pinbank_in_filter.sv
`timescale 1ns/1ps
module pinbank_in_filter #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] flt_en,
  output logic [NPINS-1:0] lvl_sync,
  output logic [NPINS-1:0] lvl_filt
);
  logic [NPINS-1:0] meta_q, sync_q, prev_q, filt_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
        filt_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= pad_in[i];
        sync_q[i] <= meta_q[i];
        prev_q[i] <= sync_q[i];
        if (!flt_en[i] || (sync_q[i] == prev_q[i]))
          filt_q[i] <= sync_q[i];
      end
    end
  end

  assign lvl_sync = sync_q;
  assign lvl_filt = filt_q;

  // R10
  filter_needs_two_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((filt_q ^ $past(filt_q)) & $past(flt_en & (sync_q ^ prev_q))) == '0));
endmodule

// File: rtl/pinbank_chg_irq.sv
`timescale 1ns/1ps
module pinbank_chg_irq #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] mask,
  input  logic             rd_clr,
  output logic [NPINS-1:0] stat,
  output logic             irq
);
  logic [NPINS-1:0] lvl_d, chg;

  assign chg = lvl ^ lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_d <= '0;
      stat  <= '0;
    end else begin
      lvl_d <= lvl;
      stat  <= (rd_clr ? '0 : stat) | chg;
    end
  end

  assign irq = |(stat & mask);

  // R8
  coincident_change_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(chg)) == $past(chg)));

  // R7
  status_rises_on_change_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(chg)) == '0));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/pinbank_padmux.sv
`timescale 1ns/1ps
module pinbank_padmux #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] own,
  input  logic [NPINS-1:0] sel_b,
  input  logic [NPINS-1:0] dout,
  input  logic [NPINS-1:0] oe,
  input  logic [NPINS-1:0] od,
  input  logic [NPINS-1:0] pa_out,
  input  logic [NPINS-1:0] pa_oe,
  input  logic [NPINS-1:0] pb_out,
  input  logic [NPINS-1:0] pb_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic val, en;
    assign val = own[i] ? dout[i] : (sel_b[i] ? pb_out[i] : pa_out[i]);
    assign en  = own[i] ? oe[i]   : (sel_b[i] ? pb_oe[i]  : pa_oe[i]);
    // open-drain: a 1 releases the pad, a 0 pulls low
    assign pad_oe[i]  = en & ~(od[i] & val);
    assign pad_out[i] = val & ~od[i];
  end
endmodule

// File: rtl/pinbank_ctrl.sv
`timescale 1ns/1ps
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_pullup,
  input  logic [NPINS-1:0]  pa_out,
  input  logic [NPINS-1:0]  pa_oe,
  input  logic [NPINS-1:0]  pb_out,
  input  logic [NPINS-1:0]  pb_oe,
  output logic              irq_out
);
  logic wr_stb, rd_stb, chg_rd;
  logic [NATTR-1:0][NPINS-1:0] attr_q;
  logic [NPINS-1:0] lvl_sync, lvl_filt, chg_stat;

  assign wr_stb = bus_en & bus_wr;
  assign rd_stb = bus_en & ~bus_wr;
  assign chg_rd = rd_stb && (bus_addr == RA_CHG_ST);

  for (genvar a = 0; a < NATTR; a++) begin : g_attr
    pinbank_setclr_reg #(.W(NPINS), .RST_ONES(attr_rst_ones(a))) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (wr_stb && (bus_addr == attr_set_addr(a))),
      .clr_stb (wr_stb && (bus_addr == attr_clr_addr(a))),
      .wdata   (bus_wdata),
      .q       (attr_q[a])
    );
  end

  pinbank_in_filter #(.NPINS(NPINS)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .flt_en   (attr_q[AT_FLT]),
    .lvl_sync (lvl_sync),
    .lvl_filt (lvl_filt)
  );

  pinbank_chg_irq #(.NPINS(NPINS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (lvl_filt),
    .mask   (attr_q[AT_MSK]),
    .rd_clr (chg_rd),
    .stat   (chg_stat),
    .irq    (irq_out)
  );

  pinbank_padmux #(.NPINS(NPINS)) u_mux (
    .own     (attr_q[AT_OWN]),
    .sel_b   (attr_q[AT_SEL]),
    .dout    (attr_q[AT_DAT]),
    .oe      (attr_q[AT_OE]),
    .od      (attr_q[AT_OD]),
    .pa_out  (pa_out),
    .pa_oe   (pa_oe),
    .pb_out  (pb_out),
    .pb_oe   (pb_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  assign pad_pullup = attr_q[AT_PU];

  always_comb begin
    bus_rdata = '0;
    if (rd_stb) begin
      case (bus_addr)
        RA_OWN_ST: bus_rdata = attr_q[AT_OWN];
        RA_OE_ST:  bus_rdata = attr_q[AT_OE];
        RA_FLT_ST: bus_rdata = attr_q[AT_FLT];
        RA_DAT_ST: bus_rdata = attr_q[AT_DAT];
        RA_PIN_ST: bus_rdata = lvl_sync;
        RA_MSK_ST: bus_rdata = attr_q[AT_MSK];
        RA_CHG_ST: bus_rdata = chg_stat;
        RA_OD_ST:  bus_rdata = attr_q[AT_OD];
        RA_PU_ST:  bus_rdata = attr_q[AT_PU];
        RA_SEL_ST: bus_rdata = attr_q[AT_SEL];
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R5
  od_high_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((attr_q[AT_OD] & attr_q[AT_OWN] & attr_q[AT_DAT] & pad_oe) == '0));
endmodule

// File: tb/sim_pinbank_ctrl.sv
`timescale 1ns/1ps
module sim_pinbank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pullup;
  logic [31:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
  logic        irq_out;

  int total = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // bench-side view of the configuration, built from the requirements
  logic [31:0] m_own = '1, m_oe = '0, m_dat = '0, m_od = '0, m_sel = '0, m_pu = '1;

  always #10 clk = ~clk;  // 50 MHz

  pinbank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pullup(pad_pullup), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_out(pb_out), .pb_oe(pb_oe), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read data and compares it mid-cycle
  initial forever begin
    @(negedge clk);
    #5;
    if (exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    case (a)
      5'd0:  m_own |= d;  5'd1:  m_own &= ~d;
      5'd3:  m_oe  |= d;  5'd4:  m_oe  &= ~d;
      5'd9:  m_dat |= d;  5'd10: m_dat &= ~d;
      5'd17: m_od  |= d;  5'd18: m_od  &= ~d;
      5'd20: m_pu  &= ~d; 5'd21: m_pu  |= d;
      5'd23: m_sel &= ~d; 5'd24: m_sel |= d;
      default: ;
    endcase
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pad_chk(input string tag);
    logic [31:0] v, e;
    v = (m_own & m_dat) | (~m_own & ~m_sel & pa_out) | (~m_own & m_sel & pb_out);
    e = (m_own & m_oe)  | (~m_own & ~m_sel & pa_oe)  | (~m_own & m_sel & pb_oe);
    @(negedge clk);
    #5;
    check({tag, " pad_out"}, pad_out, v & ~m_od);
    check({tag, " pad_oe"}, pad_oe, e & ~(m_od & v));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #5;
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    check("R1 pad_pullup", pad_pullup, 32'hFFFF_FFFF);
    check("R1 pad_oe", pad_oe, 32'd0);
    rd(5'd2,  32'hFFFF_FFFF, "R1 own");
    rd(5'd5,  32'd0, "R1 oe");
    rd(5'd8,  32'd0, "R1 filter");
    rd(5'd11, 32'd0, "R1 data");
    rd(5'd15, 32'd0, "R1 mask");
    rd(5'd16, 32'd0, "R1 chg");
    rd(5'd19, 32'd0, "R1 opendrain");
    rd(5'd22, 32'hFFFF_FFFF, "R1 pullup");
    rd(5'd25, 32'd0, "R1 select");
    // R12 write-only and unmapped read 0
    rd(5'd3,  32'd0, "R12 oe set");
    rd(5'd9,  32'd0, "R12 data set");
    rd(5'd30, 32'd0, "R12 unmapped");
    // R2 set/clear
    wr(5'd3, 32'h0000_00F0);
    wr(5'd3, 32'h0000_0003);
    rd(5'd5, 32'h0000_00F3, "R2 oe set");
    wr(5'd4, 32'h0000_0011);
    rd(5'd5, 32'h0000_00E2, "R2 oe clear");
    wr(5'd3, 32'd0);
    rd(5'd5, 32'h0000_00E2, "R2 zero write");
    // R4 GPIO drive
    wr(5'd9, 32'h0000_00A0);
    pad_chk("R4 gpio");
    wr(5'd10, 32'h0000_0020);
    rd(5'd11, 32'h0000_0080, "R4 data clear");
    pad_chk("R4 gpio after clear");
    // R3 peripheral ownership and select (status bit 1 = B)
    pa_out = 32'h1234_5678; pa_oe = 32'hFFFF_0F00;
    pb_out = 32'h00AA_0000; pb_oe = 32'h00F0_0000;
    wr(5'd1, 32'h00FF_FF00);
    wr(5'd24, 32'h00FF_0000);
    rd(5'd2,  32'hFF00_00FF, "R3 own");
    rd(5'd25, 32'h00FF_0000, "R3 select");
    pad_chk("R3 mux");
    @(negedge clk); #5;
    check("R3 pad_out literal", pad_out, 32'h00AA_5680);
    wr(5'd23, 32'h0001_0000);
    rd(5'd25, 32'h00FE_0000, "R3 select A");
    pad_chk("R3 mux after A");
    // R5 open-drain on pins 6 (data 0) and 7 (data 1)
    wr(5'd17, 32'h0000_00C0);
    rd(5'd19, 32'h0000_00C0, "R5 od status");
    pad_chk("R5 od");
    @(negedge clk); #5;
    check("R5 pin7 released, pin6 low", {30'd0, pad_oe[7:6], 1'b0, pad_out[6]}, 32'h4);
    // R11 pull-up
    wr(5'd20, 32'h0000_000F);
    @(negedge clk); #5;
    check("R11 pad_pullup", pad_pullup, 32'hFFFF_FFF0);
    rd(5'd22, 32'hFFFF_FFF0, "R11 pullup status");
    // R6 pin level, latency 2 edges, peripheral-owned pins included
    @(negedge clk);
    pad_in = 32'h5A5A_0000;
    rd(5'd12, 32'd0, "R6 one edge");
    idle(3);
    rd(5'd12, 32'h5A5A_0000, "R6 level");
    // R7 / R8 both edges, clear on read
    rd(5'd16, 32'h5A5A_0000, "R7 rising");
    rd(5'd16, 32'd0, "R8 cleared");
    pad_in = 32'd0;
    idle(5);
    rd(5'd16, 32'h5A5A_0000, "R7 falling");
    rd(5'd16, 32'd0, "R8 cleared again");
    // R8 change coincident with read
    @(negedge clk);
    pad_in[9] = 1'b1;
    idle(2);
    rd(5'd16, 32'd0, "R8 coincident read");
    rd(5'd16, 32'h0000_0200, "R8 kept");
    // R9 mask and irq
    wr(5'd13, 32'h0002_0000);
    rd(5'd15, 32'h0002_0000, "R9 mask");
    @(negedge clk);
    pad_in[17] = 1'b1;
    idle(5);
    #5;
    check("R9 irq high", {31'd0, irq_out}, 32'd1);
    rd(5'd16, 32'h0002_0000, "R9 status");
    #5;
    check("R9 irq cleared", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    pad_in[3] = 1'b1;
    idle(5);
    #5;
    check("R9 masked quiet", {31'd0, irq_out}, 32'd0);
    rd(5'd16, 32'h0000_0008, "R9 masked status");
    // R10 glitch filter on pin 0
    wr(5'd6, 32'h0000_0001);
    rd(5'd8, 32'h0000_0001, "R10 filter status");
    @(negedge clk); pad_in[0] = 1'b1;
    @(negedge clk); pad_in[0] = 1'b0;
    idle(6);
    rd(5'd16, 32'd0, "R10 short pulse rejected");
    @(negedge clk); pad_in[0] = 1'b1;
    idle(2);        pad_in[0] = 1'b0;
    idle(6);
    rd(5'd16, 32'h0000_0001, "R10 two-cycle pulse seen");
    @(negedge clk); pad_in[1] = 1'b1;
    @(negedge clk); pad_in[1] = 1'b0;
    idle(6);
    rd(5'd16, 32'h0000_0002, "R7 unfiltered short pulse");
    idle(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule